// File: doc/BRIEF.md
# Cooperative Round-Robin Thread Scheduler

This block decides which of eight hardware thread contexts owns a single processing engine. Each context keeps its own register state, so switching costs no save or restore work. The scheduler only has to name the thread that runs next. A running thread keeps the engine until it gives it up. It does this with a swap request, usually just after issuing one or more memory requests, so that another thread can run while those requests are pending. The scheduler never takes the engine away from a thread on its own.

A swap request carries a wait mask. The mask names the completion signals that the thread must see before it may run again. Completion events arrive one per cycle, each addressed to a thread with a set of signal bits. They are collected in a 16-bit signal register per thread. A signal that arrives before its thread starts waiting is held there. A parked thread becomes eligible once every bit of its mask is present in its signal register. When the thread is resumed, the bits it waited on are cleared. The next thread is chosen round-robin among eligible threads, and the search starts just after the thread that ran last. When no thread is eligible, the engine idles and reports that no thread is valid.

Top module: `thread_sched`

## Requirements
- R1: While reset is held, `curValid` is 0. Every thread leaves reset parked with an empty wait mask. On the first clock edge after reset is released, thread 0 is selected, so `curValid`=1 and `curThread`=0.
- R2: While `curValid` is 1 and `swapReq` is 0, `curThread` does not change, whatever signal events arrive.
- R3: When the running thread asserts `swapReq`, it parks with `swapMask` as its wait mask. If another thread is eligible at that edge, that thread is running in the very next cycle, with no idle cycle between them.
- R4: The search for the next thread starts at the thread numbered one above the thread that last ran. It wraps from 7 to 0 and takes the first eligible thread it finds.
- R5: A parked thread is eligible only when (signal register AND wait mask) equals the wait mask. A thread that has received only some of its mask bits is never selected.
- R6: Signal bits that arrive for a thread before it parks, including while it is running, are kept. They count toward its next wait.
- R7: When a thread is resumed, only the bits of its wait mask are cleared from its signal register. Other pending bits are kept.
- R8: If no thread is eligible when the engine is free, `curValid` is 0. A signal event that completes a parked thread's mask, driven in cycle c, makes that thread run from cycle c+2.
- R9: `swapReq` while `curValid` is 0 has no effect. In particular it parks no thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| swapReq | input | 1 | Running thread gives up the engine this cycle |
| swapMask | input | 16 | Signal bits the swapping thread waits on |
| sigValid | input | 1 | A completion event is present this cycle |
| sigThread | input | 3 | Thread that the completion event is for |
| sigBits | input | 16 | Signal bits set by the completion event |
| curValid | output | 1 | A thread owns the engine |
| curThread | output | 3 | Number of the thread that owns the engine |

## Verification
A swap takes effect at the next rising edge. The thread that takes over is therefore visible one cycle after `swapReq` is driven. A completion event is first stored in the signal register and only then drives the round-robin pick, so a wakeup becomes visible two cycles after the event. The bench drives every input just after a falling edge and reads `curValid` and `curThread` at the falling edge after the one through which the result must pass. For R8 it also reads the outputs one cycle early, to confirm that the wakeup does not arrive before its due cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int unsigned THREADS = 8;
  parameter int unsigned SIG_W   = 16;
  localparam int unsigned TID_W  = $clog2(THREADS);

  typedef logic [TID_W-1:0] tid_t;

  // strobes from control to the per-thread state
  typedef struct packed {
    logic park;      // running thread parks with the supplied mask
    tid_t parkId;
    logic resume;    // selected thread leaves the wait state
    tid_t resumeId;
  } schedStrobe_t;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int unsigned NumThreads = sched_pkg::THREADS,
  localparam int unsigned TidW = $clog2(NumThreads)
) (
  input  logic [NumThreads-1:0] readyVec,
  input  logic [TidW-1:0]       lastId,
  output logic                  found,
  output logic [TidW-1:0]       pickId
);
  // candidate order: lastId+1, lastId+2, ... wrapping, lastId itself last
  always_comb begin
    found  = 1'b0;
    pickId = '0;
    for (int off = 1; off <= int'(NumThreads); off++) begin
      int idx;
      idx = (int'(lastId) + off) % int'(NumThreads);
      if (!found && readyVec[idx]) begin
        found  = 1'b1;
        pickId = TidW'(idx);
      end
    end
  end
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath #(
  parameter int unsigned NumThreads = sched_pkg::THREADS,
  parameter int unsigned SigW       = sched_pkg::SIG_W,
  localparam int unsigned TidW = $clog2(NumThreads)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  sched_pkg::schedStrobe_t strobe,
  input  logic [SigW-1:0]         swapMask,
  input  logic                    sigValid,
  input  logic [TidW-1:0]         sigThread,
  input  logic [SigW-1:0]         sigBits,
  output logic [NumThreads-1:0]   readyVec
);
  logic [NumThreads-1:0] waiting;

  for (genvar t = 0; t < NumThreads; t++) begin : g_thread
    logic [SigW-1:0] sigReg;
    logic [SigW-1:0] maskReg;
    logic            hitSig;
    logic            hitPark;
    logic            hitResume;
    logic [SigW-1:0] sigKeep;

    assign hitSig    = sigValid      && (sigThread       == TidW'(t));
    assign hitPark   = strobe.park   && (strobe.parkId   == TidW'(t));
    assign hitResume = strobe.resume && (strobe.resumeId == TidW'(t));

    // consumed bits are dropped on resume; a same-cycle arrival is still kept
    assign sigKeep = hitResume ? (sigReg & ~maskReg) : sigReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sigReg     <= '0;
        maskReg    <= '0;
        waiting[t] <= 1'b1;
      end else begin
        sigReg <= sigKeep | (hitSig ? sigBits : '0);
        if (hitPark) begin
          maskReg    <= swapMask;
          waiting[t] <= 1'b1;
        end else if (hitResume) begin
          waiting[t] <= 1'b0;
        end
      end
    end

    assign readyVec[t] = waiting[t] && ((sigReg & maskReg) == maskReg);
  end
endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl #(
  parameter int unsigned NumThreads = sched_pkg::THREADS,
  localparam int unsigned TidW = $clog2(NumThreads)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    swapReq,
  input  logic [NumThreads-1:0]   readyVec,
  output sched_pkg::schedStrobe_t strobe,
  output logic                    curValid,
  output logic [TidW-1:0]         curThread
);
  logic [TidW-1:0] lastId;
  logic            found;
  logic [TidW-1:0] pickId;
  logic            slotFree;

  rr_picker #(.NumThreads(NumThreads)) u_pick (
    .readyVec (readyVec),
    .lastId   (lastId),
    .found    (found),
    .pickId   (pickId)
  );

  // engine may be handed over when idle or when the owner swaps out
  assign slotFree = !curValid || swapReq;

  always_comb begin
    strobe          = '0;
    strobe.park     = curValid && swapReq;
    strobe.parkId   = curThread;
    strobe.resume   = slotFree && found;
    strobe.resumeId = pickId;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValid  <= 1'b0;
      curThread <= '0;
      lastId    <= TidW'(NumThreads - 1);
    end else if (slotFree) begin
      curValid <= found;
      if (found) begin
        curThread <= pickId;
        lastId    <= pickId;
      end
    end
  end
endmodule

// File: rtl/thread_sched.sv
module thread_sched #(
  parameter int unsigned NumThreads = sched_pkg::THREADS,
  parameter int unsigned SigW       = sched_pkg::SIG_W,
  localparam int unsigned TidW = $clog2(NumThreads)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            swapReq,
  input  logic [SigW-1:0] swapMask,
  input  logic            sigValid,
  input  logic [TidW-1:0] sigThread,
  input  logic [SigW-1:0] sigBits,
  output logic            curValid,
  output logic [TidW-1:0] curThread
);
  sched_pkg::schedStrobe_t strobe;
  logic [NumThreads-1:0]   readyVec;

  sched_ctrl #(.NumThreads(NumThreads)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .swapReq   (swapReq),
    .readyVec  (readyVec),
    .strobe    (strobe),
    .curValid  (curValid),
    .curThread (curThread)
  );

  sched_datapath #(.NumThreads(NumThreads), .SigW(SigW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .swapMask  (swapMask),
    .sigValid  (sigValid),
    .sigThread (sigThread),
    .sigBits   (sigBits),
    .readyVec  (readyVec)
  );
endmodule

// File: rtl/thread_sched_checker.sv
module thread_sched_checker #(
  parameter int unsigned NumThreads = sched_pkg::THREADS,
  localparam int unsigned TidW = $clog2(NumThreads)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  swapReq,
  input logic                  curValid,
  input logic [TidW-1:0]       curThread,
  input logic [NumThreads-1:0] readyVec
);
  logic [NumThreads-1:0] prevReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReady <= '0;
    else       prevReady <= readyVec;
  end

  // R1: nothing runs while in reset
  always_comb begin
    if (!rstN) a_r1_idle_in_reset: assert (!curValid);
  end

  // R2: the owner is never displaced without its own swap
  a_r2_no_preempt: assert property (@(posedge clk) disable iff (!rstN)
    (curValid && !swapReq) |=> (curValid && curThread == $past(curThread)));

  // R3: a swapping thread is never handed the engine straight back
  a_r3_handoff_other: assert property (@(posedge clk) disable iff (!rstN)
    (curValid && swapReq) |=> (!curValid || curThread != $past(curThread)));

  // R5: a newly chosen thread was eligible in the cycle it was picked
  a_r5_pick_ready: assert property (@(posedge clk) disable iff (!rstN)
    ((!curValid || swapReq) && readyVec != '0) |=> (curValid && prevReady[curThread]));

  // R8: with no eligible thread a free engine stays idle
  a_r8_idle_when_none: assert property (@(posedge clk) disable iff (!rstN)
    ((!curValid || swapReq) && readyVec == '0) |=> !curValid);
endmodule

bind thread_sched thread_sched_checker #(.NumThreads(NumThreads)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swapReq   (swapReq),
  .curValid  (curValid),
  .curThread (curThread),
  .readyVec  (readyVec)
);

// File: tb/sim_thread_sched.sv
module sim_thread_sched;
  localparam int ClkPeriod = 10;
  localparam int Watchdog  = 10000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swapReq = 1'b0;
  logic [15:0] swapMask = '0;
  logic        sigValid = 1'b0;
  logic [2:0]  sigThread = '0;
  logic [15:0] sigBits = '0;
  logic        curValid;
  logic [2:0]  curThread;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  thread_sched u0 (
    .clk(clk), .rstN(rstN), .swapReq(swapReq), .swapMask(swapMask),
    .sigValid(sigValid), .sigThread(sigThread), .sigBits(sigBits),
    .curValid(curValid), .curThread(curThread)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_cur(string req, bit expValid, int expId);
    checks++;
    if (curValid !== expValid || (expValid && curThread !== 3'(expId))) begin
      errors++;
      $display("FAIL %s: valid=%0b thread=%0d expected valid=%0b thread=%0d",
               req, curValid, curThread, expValid, expId);
    end
  endtask

  task automatic swap(logic [15:0] mask);
    swapReq = 1'b1; swapMask = mask;
    tick();
    swapReq = 1'b0; swapMask = '0;
  endtask

  task automatic signal(int tid, logic [15:0] bits);
    sigValid = 1'b1; sigThread = 3'(tid); sigBits = bits;
    tick();
    sigValid = 1'b0; sigBits = '0;
  endtask

  task automatic t_reset();
    tick(); tick();
    expect_cur("R1 held in reset", 0, 0);
    rstN = 1'b1;
    tick();
    expect_cur("R1 first pick", 1, 0);
  endtask

  task automatic t_rotate();
    for (int k = 1; k <= 8; k++) begin
      swap(16'h0000);
      expect_cur("R3 R4 rotation", 1, k % 8);
    end
  endtask

  task automatic t_park_all();
    swap(16'h0003); expect_cur("R3 park t0", 1, 1);
    swap(16'h0001); expect_cur("R3 park t1", 1, 2);
    for (int k = 3; k <= 7; k++) begin
      swap(16'h8000); expect_cur("R3 park chain", 1, k);
    end
    swap(16'h8000);
    expect_cur("R8 idle when none ready", 0, 0);
    // R9: swap while idle must not park anything
    swapReq = 1'b1; swapMask = '0;
    tick();
    swapReq = 1'b0;
    tick(); tick();
    expect_cur("R9 idle swap ignored", 0, 0);
  endtask

  task automatic t_wait_all();
    signal(0, 16'h0001);
    tick();
    expect_cur("R5 partial mask", 0, 0);
    signal(0, 16'h0002);
    expect_cur("R8 not before c+2", 0, 0);
    tick();
    expect_cur("R8 R5 wake at c+2", 1, 0);
  endtask

  task automatic t_early_and_hold();
    signal(2, 16'h8000);
    signal(0, 16'h0010);
    expect_cur("R2 still running", 1, 0);
    swap(16'h0010);
    expect_cur("R4 skip unready t1", 1, 2);
    swap(16'h4000);
    expect_cur("R6 early signal kept", 1, 0);
    signal(1, 16'h0001);
    signal(0, 16'h0060);
    for (int k = 0; k < 4; k++) begin
      tick();
      expect_cur("R2 no preemption", 1, 0);
    end
  endtask

  task automatic t_consume();
    swap(16'h0020);
    expect_cur("R4 next after t0", 1, 1);
    swap(16'h0001);
    expect_cur("R4 wrap to t0", 1, 0);
    swap(16'h0060);
    expect_cur("R7 consumed bits cleared", 0, 0);
    tick(); tick();
    expect_cur("R7 still idle", 0, 0);
    signal(0, 16'h0020);
    tick();
    expect_cur("R7 unmasked bit kept", 1, 0);
  endtask

  initial begin
    t_reset();
    t_rotate();
    t_park_all();
    t_wait_all();
    t_early_and_hold();
    t_consume();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (Watchdog) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected finish within %0d cycles", Watchdog);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule